// File: doc/BRIEF.md
# Banked Interrupt Enable Controller

This block gathers level-sensitive interrupt lines in groups of 32, called banks, and turns them into four combined request outputs: a normal and a fast request for a main processor, and a normal and a fast request for a coprocessor. Each line counts as pending when its synchronised input is high, or when software has forced it pending. Each target has its own enable mask and its own class mask. The class mask decides whether an enabled, pending line raises that target's normal request or its fast request.

Software reaches each bank through a plain word-wide port, made of a bank index, a byte offset, a write strobe, write data and read data. The enable masks and the force mask change only through write-one-to-set and write-one-to-clear aliases. So one access can enable a single line, or disable a whole bank, without a read-modify-write. The class masks are written directly. The number of banks is a parameter from 1 to 6. Line n lives in bank n/32 at bit n%32.

Top module: `bic_ctrl`

## Requirements
- R1: After reset, every force, enable and class mask reads as zero and all four request outputs are low.
- R2: A write to a set alias ORs the written word into its mask and leaves the bits written as 0 unchanged. The set aliases are force 0x18, main enable 0x24 and coprocessor enable 0x34.
- R3: A write to a clear alias clears every mask bit written as 1 and leaves the rest. The clear aliases are force 0x1C, main enable 0x28 and coprocessor enable 0x38. Writing 0xFFFFFFFF clears the whole mask in one access.
- R4: The class masks are written and read directly: main class at 0x2C, coprocessor class at 0x3C. A class bit of 0 selects the normal request and a class bit of 1 selects the fast request.
- R5: A line is pending when its input, passed through two synchroniser flops, is high or its force bit is set. An input level sampled at clock edge k reaches the outputs after edge k+2. A register write at edge k reaches the outputs after edge k+1.
- R6: cpu_irq is the OR over all banks and lines of pending & main enable & ~main class. cpu_fiq is the same OR with main class in place of ~main class.
- R7: The coprocessor outputs cop_irq and cop_fiq are formed the same way from the coprocessor masks, independently of the main masks, so one pending line may drive both targets at once.
- R8: A read of offset 0x08 returns pending & main enable & main class for the selected bank.
- R9: Reads return the masks at these offsets: 0x14 force, 0x20 main enable, 0x30 coprocessor enable. A set or clear alias reads back its underlying mask. Writes to 0x08, 0x14, 0x20 and 0x30 change nothing. Any other offset reads zero. A bank index at or above the bank count reads zero and its writes change nothing.
- R10: Input line n is handled by bank n/32 at bit n%32, and a write to one bank leaves the other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 32*NUM_BANKS | Raw level-sensitive interrupt lines |
| bus_bank | input | 3 | Bank index for the access |
| bus_offs | input | 6 | Byte offset inside the bank |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current bank and offset, combinational |
| cpu_irq | output | 1 | Main processor normal request |
| cpu_fiq | output | 1 | Main processor fast request |
| cop_irq | output | 1 | Coprocessor normal request |
| cop_fiq | output | 1 | Coprocessor fast request |

## Verification
The properties assume that bus_bank, bus_offs, bus_wr and bus_wdata change only between clock edges and are held stable at each rising edge. They also assume that irq_in is low while reset is held, so the synchroniser starts from a known state. The stimulus drives every input on the falling edge and holds irq_in at zero through reset. Each write lasts exactly one cycle, and reads are taken with bus_wr low. Invalid bank indices and unmapped offsets are presented on purpose, but only as legal, stable values.

// File: rtl/bic_pkg.sv
package bic_pkg;
    localparam int LINES     = 32;
    localparam int MAX_BANKS = 6;
    localparam int BANK_W    = 3;
    localparam int OFFS_W    = 6;

    localparam logic [OFFS_W-1:0] OFF_FIQ_STAT = 6'h08;
    localparam logic [OFFS_W-1:0] OFF_FRC      = 6'h14;
    localparam logic [OFFS_W-1:0] OFF_FRC_SET  = 6'h18;
    localparam logic [OFFS_W-1:0] OFF_FRC_CLR  = 6'h1C;
    localparam logic [OFFS_W-1:0] OFF_CPU_EN   = 6'h20;
    localparam logic [OFFS_W-1:0] OFF_CPU_SET  = 6'h24;
    localparam logic [OFFS_W-1:0] OFF_CPU_CLR  = 6'h28;
    localparam logic [OFFS_W-1:0] OFF_CPU_CLS  = 6'h2C;
    localparam logic [OFFS_W-1:0] OFF_COP_EN   = 6'h30;
    localparam logic [OFFS_W-1:0] OFF_COP_SET  = 6'h34;
    localparam logic [OFFS_W-1:0] OFF_COP_CLR  = 6'h38;
    localparam logic [OFFS_W-1:0] OFF_COP_CLS  = 6'h3C;

    typedef struct packed {
        logic [LINES-1:0] frc;
        logic [LINES-1:0] cpu_en;
        logic [LINES-1:0] cpu_cls;
        logic [LINES-1:0] cop_en;
        logic [LINES-1:0] cop_cls;
    } bank_regs_t;

    typedef struct packed {
        logic cpu_irq;
        logic cpu_fiq;
        logic cop_irq;
        logic cop_fiq;
    } tgt_out_t;
endpackage

// File: rtl/bic_sync.sv
module bic_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = d_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_out = st_q.s2;
endmodule

// File: rtl/bic_bank.sv
module bic_bank
    import bic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [OFFS_W-1:0] offs,
    input  logic [LINES-1:0]  wdata,
    input  logic [LINES-1:0]  raw_sync,
    output bank_regs_t        regs,
    output logic [LINES-1:0]  pend,
    output logic [LINES-1:0]  rdata,
    output tgt_out_t          hits
);
    bank_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_stb) begin
            case (offs)
                OFF_FRC_SET: regs_d.frc     = regs_q.frc | wdata;
                OFF_FRC_CLR: regs_d.frc     = regs_q.frc & ~wdata;
                OFF_CPU_SET: regs_d.cpu_en  = regs_q.cpu_en | wdata;
                OFF_CPU_CLR: regs_d.cpu_en  = regs_q.cpu_en & ~wdata;
                OFF_CPU_CLS: regs_d.cpu_cls = wdata;
                OFF_COP_SET: regs_d.cop_en  = regs_q.cop_en | wdata;
                OFF_COP_CLR: regs_d.cop_en  = regs_q.cop_en & ~wdata;
                OFF_COP_CLS: regs_d.cop_cls = wdata;
                default:     regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        pend = raw_sync | regs_q.frc;
        hits.cpu_irq = |(pend & regs_q.cpu_en & ~regs_q.cpu_cls);
        hits.cpu_fiq = |(pend & regs_q.cpu_en &  regs_q.cpu_cls);
        hits.cop_irq = |(pend & regs_q.cop_en & ~regs_q.cop_cls);
        hits.cop_fiq = |(pend & regs_q.cop_en &  regs_q.cop_cls);
    end

    always_comb begin
        case (offs)
            OFF_FIQ_STAT:                         rdata = pend & regs_q.cpu_en & regs_q.cpu_cls;
            OFF_FRC, OFF_FRC_SET, OFF_FRC_CLR:    rdata = regs_q.frc;
            OFF_CPU_EN, OFF_CPU_SET, OFF_CPU_CLR: rdata = regs_q.cpu_en;
            OFF_CPU_CLS:                          rdata = regs_q.cpu_cls;
            OFF_COP_EN, OFF_COP_SET, OFF_COP_CLR: rdata = regs_q.cop_en;
            OFF_COP_CLS:                          rdata = regs_q.cop_cls;
            default:                              rdata = '0;
        endcase
    end

    assign regs = regs_q;
endmodule

// File: rtl/bic_ctrl.sv
module bic_ctrl
    import bic_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BANKS*LINES-1:0] irq_in,
    input  logic [BANK_W-1:0]          bus_bank,
    input  logic [OFFS_W-1:0]          bus_offs,
    input  logic                       bus_wr,
    input  logic [LINES-1:0]           bus_wdata,
    output logic [LINES-1:0]           bus_rdata,
    output logic                       cpu_irq,
    output logic                       cpu_fiq,
    output logic                       cop_irq,
    output logic                       cop_fiq
);
    localparam int NL = NUM_BANKS * LINES;

    logic [NL-1:0]                   raw_sync;
    bank_regs_t [NUM_BANKS-1:0]      regs_w;
    logic [NUM_BANKS-1:0][LINES-1:0] pend_w;
    logic [NUM_BANKS-1:0][LINES-1:0] rd_w;
    tgt_out_t [NUM_BANKS-1:0]        hits_w;
    tgt_out_t                        out_d, out_q;

    bic_sync #(.W(NL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (irq_in),
        .q_out (raw_sync)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = bus_wr && (bus_bank == BANK_W'(b));
        bic_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (sel),
            .offs     (bus_offs),
            .wdata    (bus_wdata),
            .raw_sync (raw_sync[b*LINES +: LINES]),
            .regs     (regs_w[b]),
            .pend     (pend_w[b]),
            .rdata    (rd_w[b]),
            .hits     (hits_w[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_bank == BANK_W'(b)) bus_rdata = rd_w[b];
        end
    end

    always_comb begin
        out_d = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            out_d = out_d | hits_w[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cpu_irq = out_q.cpu_irq;
    assign cpu_fiq = out_q.cpu_fiq;
    assign cop_irq = out_q.cop_irq;
    assign cop_fiq = out_q.cop_fiq;
endmodule

// File: rtl/bic_ctrl_chk.sv
module bic_ctrl_chk
    import bic_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [BANK_W-1:0]               bus_bank,
    input logic [OFFS_W-1:0]               bus_offs,
    input logic                            bus_wr,
    input logic [LINES-1:0]                bus_wdata,
    input bank_regs_t [NUM_BANKS-1:0]      regs_w,
    input logic [NUM_BANKS-1:0][LINES-1:0] pend_w,
    input logic                            cpu_fiq,
    input logic                            cop_irq
);
    function automatic bank_regs_t pick(input bank_regs_t [NUM_BANKS-1:0] v,
                                        input logic [BANK_W-1:0] b);
        pick = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (b == BANK_W'(i)) pick = v[i];
        end
    endfunction

    logic ok_bank;
    logic want_cpu_fiq, want_cop_irq;

    assign ok_bank = bus_bank < BANK_W'(NUM_BANKS);

    always_comb begin
        want_cpu_fiq = 1'b0;
        want_cop_irq = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            want_cpu_fiq = want_cpu_fiq | (|(pend_w[i] & regs_w[i].cpu_en & regs_w[i].cpu_cls));
            want_cop_irq = want_cop_irq | (|(pend_w[i] & regs_w[i].cop_en & ~regs_w[i].cop_cls));
        end
    end

    // R2
    cpu_set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ok_bank && bus_offs == OFF_CPU_SET)
        |=> pick(regs_w, $past(bus_bank)).cpu_en
            == ($past(pick(regs_w, bus_bank).cpu_en) | $past(bus_wdata)));

    // R3
    frc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ok_bank && bus_offs == OFF_FRC_CLR)
        |=> pick(regs_w, $past(bus_bank)).frc
            == ($past(pick(regs_w, bus_bank).frc) & ~$past(bus_wdata)));

    // R4
    cop_cls_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && ok_bank && bus_offs == OFF_COP_CLS)
        |=> pick(regs_w, $past(bus_bank)).cop_cls == $past(bus_wdata));

    // R9
    bad_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ok_bank) |=> $stable(regs_w));

    // R6
    cpu_fiq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cpu_fiq == $past(want_cpu_fiq));

    // R7
    cop_irq_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cop_irq == $past(want_cop_irq));
endmodule

bind bic_ctrl bic_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_bank  (bus_bank),
    .bus_offs  (bus_offs),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .regs_w    (regs_w),
    .pend_w    (pend_w),
    .cpu_fiq   (cpu_fiq),
    .cop_irq   (cop_irq)
);

// File: tb/sim_bic_ctrl.sv
`timescale 1ns/1ps
module sim_bic_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam int NL = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] irq_in = '0;
    logic [2:0]    bus_bank = '0;
    logic [5:0]    bus_offs = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          cpu_irq, cpu_fiq, cop_irq, cop_fiq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    typedef struct {
        bit          is_out;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bic_ctrl #(.NUM_BANKS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_bank(bus_bank), .bus_offs(bus_offs), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq),
        .cop_irq(cop_irq), .cop_fiq(cop_fiq)
    );

    // Monitor: pops each expected item and compares it with what the design shows now.
    initial begin
        forever begin
            item_t it;
            logic [31:0] got;
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            got = it.is_out ? {28'd0, cpu_irq, cpu_fiq, cop_irq, cop_fiq} : bus_rdata;
            n_checks++;
            if (got !== it.exp) begin
                n_fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] b, input logic [5:0] o, input logic [31:0] d);
        @(negedge clk);
        bus_bank = b; bus_offs = o; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] b, input logic [5:0] o,
                      input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_bank = b; bus_offs = o; bus_wr = 1'b0;
        #1;
        exp_q.push_back('{is_out: 1'b0, exp: e, tag: tag});
    endtask

    // Expected bits: {cpu_irq, cpu_fiq, cop_irq, cop_fiq}
    task automatic out_chk(input logic [3:0] e, input string tag);
        @(negedge clk);
        #1;
        exp_q.push_back('{is_out: 1'b1, exp: {28'd0, e}, tag: tag});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, 6'h20, 32'h0, "R1 cpu enable");
        rd(0, 6'h14, 32'h0, "R1 force");
        rd(1, 6'h3C, 32'h0, "R1 cop class");
        out_chk(4'b0000, "R1 outputs");

        // R2 set alias accumulates
        wr(0, 6'h24, 32'h0000_00F0);
        wr(0, 6'h24, 32'h0000_0F00);
        rd(0, 6'h20, 32'h0000_0FF0, "R2 cpu enable set");
        rd(0, 6'h24, 32'h0000_0FF0, "R9 set alias readback");
        rd(0, 6'h28, 32'h0000_0FF0, "R9 clear alias readback");

        // R3 clear alias
        wr(0, 6'h28, 32'h0000_0030);
        rd(0, 6'h20, 32'h0000_0FC0, "R3 cpu enable clear");

        // R4 class register
        wr(0, 6'h2C, 32'h0000_0F00);
        rd(0, 6'h2C, 32'h0000_0F00, "R4 cpu class");
        rd(0, 6'h3C, 32'h0, "R4 cop class untouched");

        // R5/R6 forced line, class 0 -> normal request
        wr(0, 6'h18, 32'h0000_0040);
        out_chk(4'b1000, "R6 forced irq");
        rd(0, 6'h14, 32'h0000_0040, "R9 force read");

        // R6 forced line with class 1 -> fast request, R8 status view
        wr(0, 6'h18, 32'h0000_0100);
        out_chk(4'b1100, "R6 forced fiq");
        rd(0, 6'h08, 32'h0000_0100, "R8 fiq status");

        // R3 clear force
        wr(0, 6'h1C, 32'h0000_0140);
        out_chk(4'b0000, "R3 force cleared");

        // R5 raw input latency: line 9 enabled, class 1
        @(negedge clk);
        irq_in[9] = 1'b1;
        out_chk(4'b0000, "R5 latency edge 1");
        out_chk(4'b0000, "R5 latency edge 2");
        out_chk(4'b0100, "R5 raw input arrives");

        // R7 coprocessor shares the same line
        wr(0, 6'h34, 32'h0000_0200);
        out_chk(4'b0110, "R7 both targets");
        rd(0, 6'h30, 32'h0000_0200, "R7 cop enable");

        // R3 all-ones clear disables a whole bank
        wr(0, 6'h28, 32'hFFFF_FFFF);
        wr(0, 6'h38, 32'hFFFF_FFFF);
        rd(0, 6'h20, 32'h0, "R3 all ones cpu");
        out_chk(4'b0000, "R3 bank disabled");
        irq_in[9] = 1'b0;

        // R10 line 40 -> bank 1 bit 8
        irq_in[40] = 1'b1;
        wr(1, 6'h34, 32'h0000_0100);
        wr(1, 6'h3C, 32'h0000_0100);
        out_chk(4'b0001, "R10 bank1 line 40 cop fiq");
        rd(1, 6'h30, 32'h0000_0100, "R10 bank1 enable");
        rd(0, 6'h30, 32'h0, "R10 bank0 unaffected");

        // R9 invalid bank, read-only offsets, unmapped offsets
        wr(3'd5, 6'h24, 32'hFFFF_FFFF);
        rd(3'd5, 6'h20, 32'h0, "R9 invalid bank read");
        rd(0, 6'h20, 32'h0, "R9 invalid bank no write b0");
        rd(1, 6'h20, 32'h0, "R9 invalid bank no write b1");
        wr(1, 6'h20, 32'hFFFF_FFFF);
        rd(1, 6'h20, 32'h0, "R9 direct enable write ignored");
        wr(1, 6'h14, 32'hFFFF_FFFF);
        rd(1, 6'h14, 32'h0, "R9 direct force write ignored");
        rd(1, 6'h04, 32'h0, "R9 unmapped offset");
        rd(1, 6'h00, 32'h0, "R9 unmapped offset zero");
        out_chk(4'b0001, "R9 outputs unchanged");

        @(negedge clk);
        wait (exp_q.size() == 0);
        #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule